// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a two-rank, four-byte-lane dynamic memory module alive. It holds the array idle for a start-up pause after reset. It then runs a fixed burst of initialization refresh cycles on its own, with no handshake. After that it releases the array to the access sequencer and earns one refresh credit per refresh interval. Each credit is spent by asking for the strobes through a request/grant pair.

A refresh cycle uses the memory's internal row counter. All column strobes drop first, then both row strobes drop. The column strobes return high while the row strobes are still low, and a precharge gap follows. The write enable stays high for the whole cycle. Up to a parameterised number of credits can build up while the access sequencer holds off. When the store is full, an urgency flag tells the sequencer to grant once its current access ends. A parameter selects the longer interval of the low-power memory variant.

All timing is given in clock cycles through parameters. Elaboration checks reject settings that break the ordering of the cycle or its minimum length.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, all row and column strobes and the write enable are high, and ref_req, ref_urgent, ref_busy and init_done are low.
- R2: For the first STARTUP_CYC clock edges after reset release, no strobe goes low.
- R3: Right after the pause, exactly INIT_BURST refresh cycles run without any grant, separated by one idle cycle. init_done rises on the edge after the last precharge cycle, and ref_busy is low in the first cycle it is high.
- R4: In every refresh cycle all NUM_CAS column strobes fall together. The row strobes fall CSR_CYC cycles later.
- R5: The column strobes stay low for CHR_CYC cycles after the row strobes fall, then rise while the row strobes are still low.
- R6: All NUM_RANKS row strobes move together and stay low for RAS_LOW_CYC cycles. RP_CYC precharge cycles plus one idle cycle follow before the next column strobe fall.
- R7: we_n is high at all times.
- R8: After init_done rises, one credit is earned every INTERVAL cycles. INTERVAL is INTERVAL_LP when LOW_POWER is 1 and INTERVAL_STD otherwise. With ref_gnt held high, consecutive row strobe falls are exactly INTERVAL cycles apart.
- R9: ref_req is high exactly when init_done is high, at least one credit is held and no refresh cycle is in progress. When ref_req and ref_gnt are both high at a clock edge, the column strobes are low in the next cycle.
- R10: Credits saturate at MAX_PEND, and ref_urgent is high exactly when MAX_PEND credits are held. From a full store with ref_gnt held high, MAX_PEND refresh cycles run back to back with no gap beyond the idle cycle.
- R11: ref_busy is high from the first cycle with column strobes low through the last precharge cycle. It is low whenever all strobes are idle.
- R12: A cycle with ref_req high and ref_gnt low starts no refresh: ref_busy stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| ref_gnt | input | 1 | Access sequencer hands the strobes over for one refresh |
| ref_req | output | 1 | A credit is waiting and the strobe sequencer is idle |
| ref_urgent | output | 1 | The credit store is full |
| ref_busy | output | 1 | A refresh cycle owns the strobes |
| init_done | output | 1 | Pause and initialization burst are complete |
| ras_n | output | NUM_RANKS | Row strobes, one per rank, active low |
| cas_n | output | NUM_CAS | Column strobes, one per byte lane, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The bench builds the block with LOW_POWER set to 1. It uses a 20-cycle pause, a 30-cycle standard interval and a 60-cycle low-power interval, so the choice of interval is visible in how far apart the refreshes fall. Two-cycle lead and hold windows, a five-cycle row-low time and a three-cycle precharge let every phase boundary be measured on its own. A credit limit of eight is reached within a few hundred cycles of withheld grants, which brings saturation, the urgency flag and the back-to-back drain into a short run. Random grant patterns then exercise grants that arrive late, early and during busy cycles.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   typedef enum logic [1:0] {
      PH_PAUSE = 2'd0,
      PH_INIT  = 2'd1,
      PH_RUN   = 2'd2
   } phase_t;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_LEAD = 3'd1,
      SQ_HOLD = 3'd2,
      SQ_TAIL = 3'd3,
      SQ_PRE  = 3'd4
   } seq_t;
endpackage

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
   import rfsh_pkg::*;
#(
   parameter int NUM_RANKS   = 2,
   parameter int NUM_CAS     = 4,
   parameter int CSR_CYC     = 1,
   parameter int CHR_CYC     = 1,
   parameter int RAS_LOW_CYC = 6,
   parameter int RP_CYC      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   output logic                 busy,
   output logic [NUM_RANKS-1:0] ras_n,
   output logic [NUM_CAS-1:0]   cas_n
);
   localparam int TAIL_CYC = RAS_LOW_CYC - CHR_CYC;
   localparam int MAX_LEN  = (CSR_CYC > RAS_LOW_CYC) ?
                             ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC) :
                             ((RAS_LOW_CYC > RP_CYC) ? RAS_LOW_CYC : RP_CYC);
   localparam int CW = $clog2(MAX_LEN + 1);

   seq_t          state;
   logic [CW-1:0] cnt;
   logic          row_low;
   logic          col_low;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (start) begin
               state <= SQ_LEAD;
               cnt   <= CW'(CSR_CYC - 1);
            end
            SQ_LEAD: if (cnt == '0) begin
               state <= SQ_HOLD;
               cnt   <= CW'(CHR_CYC - 1);
            end else cnt <= cnt - 1'b1;
            SQ_HOLD: if (cnt == '0) begin
               state <= SQ_TAIL;
               cnt   <= CW'(TAIL_CYC - 1);
            end else cnt <= cnt - 1'b1;
            SQ_TAIL: if (cnt == '0) begin
               state <= SQ_PRE;
               cnt   <= CW'(RP_CYC - 1);
            end else cnt <= cnt - 1'b1;
            SQ_PRE: if (cnt == '0) begin
               state <= SQ_IDLE;
               cnt   <= '0;
            end else cnt <= cnt - 1'b1;
            default: begin
               state <= SQ_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign busy    = (state != SQ_IDLE);
   assign row_low = (state == SQ_HOLD) || (state == SQ_TAIL);
   assign col_low = (state == SQ_LEAD) || (state == SQ_HOLD);

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      assign ras_n[r] = ~row_low;
   end
   for (genvar c = 0; c < NUM_CAS; c++) begin : g_lane
      assign cas_n[c] = ~col_low;
   end
endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
   parameter int INTERVAL_STD = 1560,
   parameter int INTERVAL_LP  = 6240,
   parameter bit LOW_POWER    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int LIMIT = LOW_POWER ? INTERVAL_LP : INTERVAL_STD;
   localparam int TW    = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == TW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (!en)    cnt <= '0;
      else if (wrap)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   assign tick = en && wrap;
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
   parameter int MAX_PEND = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         add,
   input  logic                         take,
   output logic [$clog2(MAX_PEND+1)-1:0] count,
   output logic                         full
);
   localparam int KW = $clog2(MAX_PEND + 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         case ({add, take})
            2'b10:   if (!full) count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full = (count == KW'(MAX_PEND));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
   import rfsh_pkg::*;
#(
   parameter int NUM_RANKS    = 2,
   parameter int NUM_CAS      = 4,
   parameter int STARTUP_CYC  = 20000,
   parameter int INIT_BURST   = 8,
   parameter int INTERVAL_STD = 1560,
   parameter int INTERVAL_LP  = 6240,
   parameter bit LOW_POWER    = 1'b0,
   parameter int CSR_CYC      = 1,
   parameter int CHR_CYC      = 1,
   parameter int RAS_LOW_CYC  = 6,
   parameter int RP_CYC       = 4,
   parameter int MIN_RC_CYC   = 11,
   parameter int MAX_PEND     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ref_gnt,
   output logic                 ref_req,
   output logic                 ref_urgent,
   output logic                 ref_busy,
   output logic                 init_done,
   output logic [NUM_RANKS-1:0] ras_n,
   output logic [NUM_CAS-1:0]   cas_n,
   output logic                 we_n
);
   localparam int PW = $clog2(STARTUP_CYC + 1);
   localparam int IW = $clog2(INIT_BURST + 1);
   localparam int KW = $clog2(MAX_PEND + 1);

   if (CSR_CYC < 1 || CHR_CYC < 1 || RP_CYC < 1) begin : g_bad_phase
      $error("every strobe phase needs at least one cycle");
   end
   if (RAS_LOW_CYC <= CHR_CYC) begin : g_bad_hold
      $error("row-low time must exceed the column hold time");
   end
   if (CSR_CYC + RAS_LOW_CYC + RP_CYC < MIN_RC_CYC) begin : g_bad_rc
      $error("refresh cycle shorter than the minimum cycle time");
   end
   if (STARTUP_CYC < 1 || INIT_BURST < 1 || MAX_PEND < 1) begin : g_bad_cnt
      $error("pause, burst and credit limit must be positive");
   end
   if (INTERVAL_STD < 2 || INTERVAL_LP < 2) begin : g_bad_intv
      $error("refresh intervals must be at least two cycles");
   end

   phase_t          phase;
   logic [PW-1:0]   pause_cnt;
   logic [IW-1:0]   init_left;
   logic            seq_busy;
   logic            seq_start;
   logic            grant_take;
   logic            tick;
   logic [KW-1:0]   credits;
   logic            credit_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_PAUSE;
         pause_cnt <= '0;
         init_left <= IW'(INIT_BURST);
      end else begin
         case (phase)
            PH_PAUSE: begin
               if (pause_cnt == PW'(STARTUP_CYC - 1)) phase <= PH_INIT;
               else pause_cnt <= pause_cnt + 1'b1;
            end
            PH_INIT: begin
               if (!seq_busy) begin
                  if (init_left == '0) phase <= PH_RUN;
                  else init_left <= init_left - 1'b1;
               end
            end
            default: phase <= PH_RUN;
         endcase
      end
   end

   assign init_done  = (phase == PH_RUN);
   assign ref_req    = init_done && (credits != '0) && !seq_busy;
   assign grant_take = ref_req && ref_gnt;
   assign seq_start  = ((phase == PH_INIT) && !seq_busy && (init_left != '0))
                       || grant_take;
   assign ref_urgent = init_done && credit_full;
   assign ref_busy   = seq_busy;
   assign we_n       = 1'b1;

   rfsh_interval #(
      .INTERVAL_STD (INTERVAL_STD),
      .INTERVAL_LP  (INTERVAL_LP),
      .LOW_POWER    (LOW_POWER)
   ) u_interval (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (init_done),
      .tick  (tick)
   );

   rfsh_credit #(
      .MAX_PEND (MAX_PEND)
   ) u_credit (
      .clk   (clk),
      .rst_n (rst_n),
      .add   (tick),
      .take  (grant_take),
      .count (credits),
      .full  (credit_full)
   );

   cbr_strobe_seq #(
      .NUM_RANKS   (NUM_RANKS),
      .NUM_CAS     (NUM_CAS),
      .CSR_CYC     (CSR_CYC),
      .CHR_CYC     (CHR_CYC),
      .RAS_LOW_CYC (RAS_LOW_CYC),
      .RP_CYC      (RP_CYC)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (seq_start),
      .busy  (seq_busy),
      .ras_n (ras_n),
      .cas_n (cas_n)
   );
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
   parameter int NUM_RANKS   = 2,
   parameter int NUM_CAS     = 4,
   parameter int STARTUP_CYC = 20000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ref_gnt,
   input logic                 ref_req,
   input logic                 ref_urgent,
   input logic                 ref_busy,
   input logic                 init_done,
   input logic [NUM_RANKS-1:0] ras_n,
   input logic [NUM_CAS-1:0]   cas_n,
   input logic                 we_n
);
   localparam int CW = $clog2(STARTUP_CYC + 2);
   logic [CW-1:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != CW'(STARTUP_CYC)) since_rst <= since_rst + 1'b1;
   end

   // R2
   pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < CW'(STARTUP_CYC)) |-> (&ras_n && &cas_n));

   // R3
   release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> !ref_busy);

   // R4
   cas_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n[0]) |-> &ras_n);

   // R5
   cas_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n[0]) |-> (cas_n == '0));

   // R6
   ranks_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n == '0) || (&ras_n));

   // R4
   lanes_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n == '0) || (&cas_n));

   // R11
   idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_busy |-> (&ras_n && &cas_n && we_n));

   // R12
   no_grant_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && ref_req && !ref_gnt) |=> !ref_busy);

   // R10
   urgent_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> (ref_req || ref_busy));
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
   .NUM_RANKS   (NUM_RANKS),
   .NUM_CAS     (NUM_CAS),
   .STARTUP_CYC (STARTUP_CYC)
) u_chk (.*);

// File: tb/test_cbr_refresh_sched.sv
module test_cbr_refresh_sched;
   localparam int CLK_PERIOD = 10;
   localparam int P_RANKS = 2, P_CAS = 4, P_STARTUP = 20, P_BURST = 8;
   localparam int P_STD = 30, P_LP = 60, P_CSR = 2, P_CHR = 2;
   localparam int P_RASLO = 5, P_RP = 3, P_RC = 10, P_MAXP = 8;
   localparam int P_TOTAL = P_CSR + P_RASLO + P_RP;
   localparam int P_INTV = P_LP;
   localparam int WATCHDOG = 20000;

   logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
   logic ref_req, ref_urgent, ref_busy, init_done, we_n;
   logic [P_RANKS-1:0] ras_n;
   logic [P_CAS-1:0] cas_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   cbr_refresh_sched #(
      .NUM_RANKS(P_RANKS), .NUM_CAS(P_CAS), .STARTUP_CYC(P_STARTUP),
      .INIT_BURST(P_BURST), .INTERVAL_STD(P_STD), .INTERVAL_LP(P_LP),
      .LOW_POWER(1'b1), .CSR_CYC(P_CSR), .CHR_CYC(P_CHR),
      .RAS_LOW_CYC(P_RASLO), .RP_CYC(P_RP), .MIN_RC_CYC(P_RC), .MAX_PEND(P_MAXP)
   ) i_cbr_refresh_sched (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
      .ref_urgent(ref_urgent), .ref_busy(ref_busy), .init_done(init_done),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
   );

   int n_chk = 0, n_fail = 0;
   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural reference: timeline of refresh cycles and credit bookkeeping
   int m_phase = 0, m_cyc = 0, m_left = P_BURST, m_off = -1, m_pend = 0, m_tmr = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_cyc = 0; m_left = P_BURST; m_off = -1; m_pend = 0; m_tmr = 0;
      end else begin
         bit idle, req, start, tick;
         idle  = (m_off < 0);
         req   = (m_phase == 2) && (m_pend > 0) && idle;
         start = ((m_phase == 1) && idle && (m_left > 0)) || (req && ref_gnt);
         tick  = (m_phase == 2) && (m_tmr == P_INTV - 1);
         if (!idle) m_off = (m_off == P_TOTAL - 1) ? -1 : m_off + 1;
         else if (start) m_off = 0;
         if (m_phase == 0) begin
            if (m_cyc == P_STARTUP - 1) m_phase = 1; else m_cyc++;
         end else if (m_phase == 1) begin
            if (idle) begin
               if (m_left == 0) m_phase = 2; else m_left--;
            end
         end else begin
            m_tmr  = tick ? 0 : m_tmr + 1;
            m_pend = m_pend + (tick ? 1 : 0) - ((req && ref_gnt) ? 1 : 0);
            if (m_pend > P_MAXP) m_pend = P_MAXP;
         end
      end
   end

   // per-cycle comparison and edge measurements
   int cyc = 0, t_casf = 0, t_rasf = 0, n_rasf = 0;
   int ras_times[$];
   logic p_ras = 1'b1, p_cas = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_col, e_row;
         cyc++;
         e_col = (m_off >= 0) && (m_off < P_CSR + P_CHR);
         e_row = (m_off >= P_CSR) && (m_off < P_CSR + P_RASLO);
         chk(ras_n == {P_RANKS{~e_row}}, "R6", "ras_n", int'(ras_n), int'({P_RANKS{~e_row}}));
         chk(cas_n == {P_CAS{~e_col}}, "R4", "cas_n", int'(cas_n), int'({P_CAS{~e_col}}));
         chk(we_n == 1'b1, "R7", "we_n", int'(we_n), 1);
         chk(init_done == (m_phase == 2), "R3", "init_done", int'(init_done), int'(m_phase == 2));
         chk(ref_req == ((m_phase == 2) && m_pend > 0 && m_off < 0), "R9", "ref_req",
             int'(ref_req), int'((m_phase == 2) && m_pend > 0 && m_off < 0));
         chk(ref_urgent == ((m_phase == 2) && m_pend == P_MAXP), "R10", "ref_urgent",
             int'(ref_urgent), int'((m_phase == 2) && m_pend == P_MAXP));
         chk(ref_busy == (m_off >= 0), "R11", "ref_busy", int'(ref_busy), int'(m_off >= 0));
         if (p_cas && !cas_n[0]) t_casf = cyc;
         if (p_ras && !ras_n[0]) begin
            t_rasf = cyc; n_rasf++; ras_times.push_back(cyc);
            chk(t_rasf - t_casf == P_CSR, "R4", "cas lead", t_rasf - t_casf, P_CSR);
         end
         if (!p_cas && cas_n[0])
            chk(cyc - t_rasf == P_CHR, "R5", "cas hold", cyc - t_rasf, P_CHR);
         if (!p_ras && ras_n[0])
            chk(cyc - t_rasf == P_RASLO, "R6", "ras low", cyc - t_rasf, P_RASLO);
         p_ras = ras_n[0]; p_cas = cas_n[0];
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int first_cas;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(&ras_n && &cas_n && we_n, "R1", "strobes in reset", int'({ras_n, cas_n}), 63);
      chk(!ref_req && !ref_urgent && !ref_busy && !init_done, "R1", "flags in reset",
          int'({ref_req, ref_urgent, ref_busy, init_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(&ras_n && &cas_n && !init_done, "R1", "after release", int'(init_done), 0);
      // R2 pause, R3 burst without grant
      first_cas = -1;
      while (!init_done) begin
         @(negedge clk);
         if (first_cas < 0 && !cas_n[0]) first_cas = cyc;
      end
      chk(first_cas == P_STARTUP + 1, "R2", "first cas fall cycle", first_cas, P_STARTUP + 1);
      chk(n_rasf == P_BURST, "R3", "init refresh count", n_rasf, P_BURST);
      chk(!ref_busy, "R3", "idle at release", int'(ref_busy), 0);
      // R8 interval spacing with grant held
      ref_gnt = 1'b1;
      ras_times.delete();
      repeat (5 * P_INTV + 5) @(negedge clk);
      chk(ras_times.size() >= 4, "R8", "refreshes seen", ras_times.size(), 5);
      for (int i = 1; i < ras_times.size(); i++)
         chk(ras_times[i] - ras_times[i-1] == P_INTV, "R8", "spacing",
             ras_times[i] - ras_times[i-1], P_INTV);
      // R12 withheld grant: no strobes
      ref_gnt = 1'b0;
      repeat (P_TOTAL + 2) @(negedge clk);
      n_rasf = 0;
      repeat ((P_MAXP + 2) * P_INTV) @(negedge clk);
      chk(n_rasf == 0, "R12", "refreshes without grant", n_rasf, 0);
      chk(ref_urgent && ref_req, "R10", "urgent when full", int'(ref_urgent), 1);
      // R10 drain back to back
      ref_gnt = 1'b1;
      n_rasf = 0;
      repeat (P_MAXP * (P_TOTAL + 1)) @(negedge clk);
      chk(n_rasf == P_MAXP, "R10", "back-to-back drain", n_rasf, P_MAXP);
      // R9 random grants
      begin
         logic [15:0] lfsr = 16'hB5C3;
         for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ref_gnt = lfsr[0] & lfsr[5];
            @(negedge clk);
         end
      end
      ref_gnt = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule